// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the programmable feedback divider of a frequency-synthesizer loop. It sits behind an external dual-modulus prescaler that divides the oscillator by M+1 or by M. It drives that prescaler's modulus-select line and counts the prescaler's output pulses. A swallow counter of length N1 and a main counter of length N2 run side by side. The prescaler divides by M+1 while the swallow counter is still short of N1. Once it reaches N1, the prescaler divides by M until the main counter completes N2 pulses. The oscillator is therefore divided by M·N2 + N1 overall, and the block emits one comparison pulse per division cycle for the phase detector.

A mode input selects direct division instead. In that mode the swallow counter stays idle, the modulus select stays low, and only the main counter divides, by N2. The N1, N2 and mode inputs may change at any time. They are captured into shadow registers only on the terminal prescaler pulse of a cycle, so a running period is never disturbed. The block is clocked at the oscillator rate, and each prescaler output pulse arrives as a one-clock strobe.

Top module: `pswallow_div`

## Requirements
- R1: During and directly after reset, `cmp_pulse_o` is low and `mod_sel_o` is high. The shadow configuration resets to swallow mode with N1 = DEF_N1 (3) and N2 = DEF_N2 (10).
- R2: In swallow mode (`swallow_i` = 1), consecutive comparison pulses are spaced M·N2 + N1 clock cycles apart when the behavioural prescaler divides by M+1 while `mod_sel_o` = 1 and by M while `mod_sel_o` = 0.
- R3: At the start of each swallow-mode cycle with N1 > 0, `mod_sel_o` is 1. It drops to 0 on the N1-th prescaler strobe of the cycle and stays 0 until the cycle ends.
- R4: In direct mode (`swallow_i` = 0), `mod_sel_o` stays 0 and pulses are N2 strobes apart, which is M·N2 clocks.
- R5: `cmp_pulse_o` is high for exactly one clock, in the cycle after the N2-th strobe of a division cycle.
- R6: N1, N2 and mode are sampled only on the strobe that ends a cycle. Changes applied at any other time have no effect on the period in progress.
- R7: Boundary values: with N1 = 0 in swallow mode, `mod_sel_o` stays 0 and the period is M·N2. With N1 = N2−1, and with N2 = 1, the period still follows R2 and R4.
- R8: In a clock with no prescaler strobe, `mod_sel_o` does not change and no comparison pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_tick_i | input | 1 | One-clock strobe per prescaler output pulse |
| swallow_i | input | 1 | 1 = pulse-swallow mode, 0 = direct division |
| n1_i | input | N1_W | Swallow count N1 |
| n2_i | input | N2_W | Main count N2 |
| mod_sel_o | output | 1 | 1 = prescaler divides by M+1, 0 = by M |
| cmp_pulse_o | output | 1 | One-clock comparison pulse per division cycle |

## Verification
The assertions assume a legal configuration: N2 ≥ 1 and, in swallow mode, N1 < N2. The prescaler strobe must be spaced at least two clocks apart. Under those assumptions the main count stays below N2, the modulus select only moves on a strobe, and the shadow values only change at a boundary. The stimulus draws N2 in 1..40 and N1 below N2. A behavioural prescaler with M = 4 always spends at least three clocks per division. Configuration is changed only after each comparison pulse, so every period has a known expected value.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    DIV_DIRECT  = 1'b0,
    DIV_SWALLOW = 1'b1
  } div_mode_e;
endpackage

// File: rtl/psd_counter.sv
module psd_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/psd_cfg_shadow.sv
module psd_cfg_shadow
  import psd_pkg::*;
#(
  parameter int N1_W   = 6,
  parameter int N2_W   = 10,
  parameter int DEF_N1 = 3,
  parameter int DEF_N2 = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            swallow_i,
  input  logic [N1_W-1:0] n1_i,
  input  logic [N2_W-1:0] n2_i,
  output div_mode_e       mode_o,
  output logic [N1_W-1:0] n1_o,
  output logic [N2_W-1:0] n2_o
);
  div_mode_e       mode_q;
  logic [N1_W-1:0] n1_q;
  logic [N2_W-1:0] n2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= DIV_SWALLOW;
      n1_q   <= N1_W'(DEF_N1);
      n2_q   <= N2_W'(DEF_N2);
    end else if (load_i) begin
      mode_q <= swallow_i ? DIV_SWALLOW : DIV_DIRECT;
      n1_q   <= n1_i;
      n2_q   <= n2_i;
    end
  end

  assign mode_o = mode_q;
  assign n1_o   = n1_q;
  assign n2_o   = n2_q;
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import psd_pkg::*;
#(
  parameter int N1_W   = 6,
  parameter int N2_W   = 10,
  parameter int DEF_N1 = 3,
  parameter int DEF_N2 = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pre_tick_i,
  input  logic            swallow_i,
  input  logic [N1_W-1:0] n1_i,
  input  logic [N2_W-1:0] n2_i,
  output logic            mod_sel_o,
  output logic            cmp_pulse_o
);
  div_mode_e       mode_q;
  logic [N1_W-1:0] n1_q;
  logic [N2_W-1:0] n2_q;
  logic [N1_W-1:0] sw_cnt;
  logic [N2_W-1:0] main_cnt;
  logic            last_tick;
  logic            wrap;
  logic            swallowing;
  logic            pulse_q;

  // terminal strobe of the division cycle
  assign last_tick  = (main_cnt == n2_q - N2_W'(1));
  assign wrap       = pre_tick_i && last_tick;
  assign swallowing = (mode_q == DIV_SWALLOW) && (sw_cnt != n1_q);

  psd_cfg_shadow #(
    .N1_W  (N1_W),
    .N2_W  (N2_W),
    .DEF_N1(DEF_N1),
    .DEF_N2(DEF_N2)
  ) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (wrap),
    .swallow_i(swallow_i),
    .n1_i     (n1_i),
    .n2_i     (n2_i),
    .mode_o   (mode_q),
    .n1_o     (n1_q),
    .n2_o     (n2_q)
  );

  psd_counter #(.W(N2_W)) u_main (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(pre_tick_i),
    .clr_i (wrap),
    .cnt_o (main_cnt)
  );

  psd_counter #(.W(N1_W)) u_swallow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(pre_tick_i && swallowing),
    .clr_i (wrap),
    .cnt_o (sw_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= wrap;
  end

  assign mod_sel_o   = swallowing;
  assign cmp_pulse_o = pulse_q;
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int N1_W = 6,
  parameter int N2_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pre_tick_i,
  input logic            mod_sel_o,
  input logic            cmp_pulse_o,
  input logic            mode_sw,
  input logic [N1_W-1:0] n1_q,
  input logic [N2_W-1:0] n2_q,
  input logic [N2_W-1:0] main_cnt
);
  AST_PULSE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_pulse_o |=> !cmp_pulse_o); // R5

  AST_PULSE_FROM_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_pulse_o) |-> $past(pre_tick_i)); // R5

  AST_CYCLE_START_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_pulse_o && mode_sw && (n1_q != '0)) |-> mod_sel_o); // R3

  AST_DIRECT_SEL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_sw |-> !mod_sel_o); // R4

  AST_SEL_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_tick_i |=> ($stable(mod_sel_o) && !cmp_pulse_o)); // R8

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_pulse_o |-> ($stable(n1_q) && $stable(n2_q) && $stable(mode_sw))); // R6

  AST_MAIN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n2_q != '0) |-> (main_cnt < n2_q)); // R2
endmodule

bind pswallow_div psd_checker #(.N1_W(N1_W), .N2_W(N2_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pre_tick_i (pre_tick_i),
  .mod_sel_o  (mod_sel_o),
  .cmp_pulse_o(cmp_pulse_o),
  .mode_sw    (mode_q == psd_pkg::DIV_SWALLOW),
  .n1_q       (n1_q),
  .n2_q       (n2_q),
  .main_cnt   (main_cnt)
);

// File: tb/tb_pswallow_div.sv
module tb_pswallow_div;
  localparam int N1_W = 6;
  localparam int N2_W = 10;
  localparam int DEF_N1 = 3;
  localparam int DEF_N2 = 10;
  localparam int M = 4;
  localparam int N_DIR = 7;
  localparam int N_RND = 40;
  localparam int WDOG = 2000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pre_tick_i = 1'b0;
  logic swallow_i;
  logic [N1_W-1:0] n1_i;
  logic [N2_W-1:0] n2_i;
  logic mod_sel_o;
  logic cmp_pulse_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic go = 1'b0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pswallow_div #(.N1_W(N1_W), .N2_W(N2_W), .DEF_N1(DEF_N1), .DEF_N2(DEF_N2)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_tick_i(pre_tick_i), .swallow_i(swallow_i),
    .n1_i(n1_i), .n2_i(n2_i), .mod_sel_o(mod_sel_o), .cmp_pulse_o(cmp_pulse_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_period(input logic sw, input int n1, input int n2);
    return sw ? M * n2 + n1 : M * n2;
  endfunction

  function automatic logic exp_start_sel(input logic sw, input int n1);
    return sw && (n1 != 0);
  endfunction

  // behavioural prescaler: divides by M+1 or M, modulus read at division start
  initial begin
    wait (go);
    forever begin
      logic sel0;
      int m;
      sel0 = mod_sel_o;
      m = sel0 ? M + 1 : M;
      pre_tick_i = 1'b0;
      for (int i = 0; i < m - 1; i++) begin
        @(negedge clk_i);
        check("R8 sel held without strobe", int'(mod_sel_o), int'(sel0));
      end
      pre_tick_i = 1'b1;
      @(negedge clk_i);
    end
  end

  task automatic pick(input int k, output logic sw, output int n1, output int n2);
    case (k)
      0: begin sw = 1'b1; n1 = 5;  n2 = 12; end
      1: begin sw = 1'b1; n1 = 0;  n2 = 6;  end   // R7 N1=0
      2: begin sw = 1'b1; n1 = 8;  n2 = 9;  end   // R7 N1=N2-1
      3: begin sw = 1'b0; n1 = 7;  n2 = 7;  end   // R4 direct
      4: begin sw = 1'b1; n1 = 0;  n2 = 1;  end   // R7 N2=1
      5: begin sw = 1'b0; n1 = 3;  n2 = 1;  end   // R7 direct N2=1
      6: begin sw = 1'b1; n1 = 1;  n2 = 2;  end
      default: begin
        n2 = 1 + int'($urandom % 40);
        n1 = int'($urandom % n2);
        sw = ($urandom % 4) != 0;
      end
    endcase
  endtask

  initial begin
    logic act_sw, nsw;
    int act_n1, act_n2, nn1, nn2, t_last, waited;
    logic timeout;
    void'($urandom(32'd20240611));
    timeout = 1'b0;
    pick(0, nsw, nn1, nn2);
    swallow_i = nsw; n1_i = N1_W'(nn1); n2_i = N2_W'(nn2);
    repeat (3) @(negedge clk_i);
    check("R1 reset pulse low", int'(cmp_pulse_o), 0);
    check("R1 reset sel high", int'(mod_sel_o), 1);
    rst_ni = 1'b1;
    go = 1'b1;
    t_last = cyc;
    act_sw = 1'b1; act_n1 = DEF_N1; act_n2 = DEF_N2;
    for (int k = 1; k <= N_DIR + N_RND && !timeout; k++) begin
      waited = 0;
      do begin
        @(negedge clk_i);
        waited++;
      end while (!cmp_pulse_o && waited < WDOG);
      if (!cmp_pulse_o) begin
        timeout = 1'b1;
        check("watchdog no pulse", 0, 1);
      end else begin
        // R2/R4/R6/R7: period matches configuration active for it
        check(act_sw ? "R2 R6 R7 swallow period" : "R4 R6 direct period",
              cyc - t_last, exp_period(act_sw, act_n1, act_n2));
        t_last = cyc;
        act_sw = swallow_i; act_n1 = int'(n1_i); act_n2 = int'(n2_i);
        check("R3 sel at cycle start", int'(mod_sel_o),
              int'(exp_start_sel(act_sw, act_n1)));
        if (k < N_DIR) pick(k, nsw, nn1, nn2);
        else           pick(99, nsw, nn1, nn2);
        swallow_i = nsw; n1_i = N1_W'(nn1); n2_i = N2_W'(nn2);
        if (act_n2 > 1) begin
          @(negedge clk_i);
          check("R5 pulse one clock", int'(cmp_pulse_o), 0);
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule